// File: doc/BRIEF.md
# Prescaled Watchdog Timer

The block is a bus-mapped watchdog. A 16-bit up-counter advances on ticks drawn from one of three tick-enable inputs and passed through a power-of-four prescaler. Each tick-enable input is a single-cycle pulse that is synchronous to the bus clock. When the counter reaches a programmed compare value while counting is enabled, the block holds a system-reset request high for a fixed number of bus cycles. It then freezes until software intervenes.

Software keeps the system alive by writing zero to the counter register often enough. That write clears the count and the prescaler, so every kick starts a full timeout period. Software may rewrite the compare, counter and control registers at any time. After a disable and re-enable, counting resumes from the values just written.

Top module: `presc_watchdog`

## Requirements
- R1: After reset, all four registers read zero and `reset_req_o` is low.
- R2: Register decoding uses `addr_i[3:2]`, and `addr_i[1:0]` is ignored. Index 0 (offset 0x0) is the 16-bit compare value. Index 1 (0x4) is the enable register, where bit 0 is the count enable and the other bits read 0. Index 2 (0x8) is the counter. Index 3 (0xC) is the control register: bits [2:0] are the source selects, bits [5:3] are the prescale code, and bits [15:6] read 0. Every register reads back its current value.
- R3: Control bit i selects `tick_i[i]`. A selected tick pulse counts toward the prescaler. A pulse on an unselected input has no effect, and with no select bit set the counter never advances.
- R4: The counter advances by one for every 4^code selected ticks, for prescale codes 0 to 5. Codes 6 and 7 divide by 1024. The counter wraps from 0xFFFF to 0.
- R5: While the enable bit is 0, the counter holds its value. Writing the enable bit to 0 clears the prescaler.
- R6: A write to the counter loads the written value and clears the prescaler. A write of zero is the kick that restarts the timeout period.
- R7: When the block is enabled and the counter equals the compare value, `reset_req_o` rises on the next cycle and stays high for exactly 16 cycles. The counter then stays frozen, ignoring ticks, until the next counter write or enable write. A match that occurs while a request is already high does not extend the request.
- R8: A counter write in the same cycle as a match overrides the match. No reset request follows, and the written value is loaded.
- R9: After a timeout, new register values can be written, followed by clearing and then setting the enable bit. Counting then resumes from the current counter value against the new compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register byte address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| tick_i | input | 3 | Tick-enable pulses from the three sources |
| reset_req_o | output | 1 | System-reset request |

## Verification
A software kick and a counter match can fall in the same cycle, and the kick must win. The bench steps the counter onto the compare value with a single tick. In the very next cycle, while the match is visible, it writes zero to the counter. It then judges the outcome from two observations: `reset_req_o` must stay low for the following twenty cycles, and the counter must read zero. A second case lets the match go through and measures the request width, and checks that the counter stays frozen while ticks continue to arrive.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned SRC_N  = 3;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned CTRL_W = SRC_N + CODE_W;
  localparam int unsigned REG_N  = 4;
  localparam int unsigned IDX_LSB = 2;

  typedef enum logic [1:0] {
    REG_CMP  = 2'd0,
    REG_EN   = 2'd1,
    REG_CNT  = 2'd2,
    REG_CTRL = 2'd3
  } wdt_reg_e;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [SRC_N-1:0]  src;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] cnt_i,
  output logic [DATA_W-1:0] cmp_o,
  output logic              en_o,
  output wdt_ctrl_t         ctrl_o,
  output logic              cnt_wr_o,
  output logic              en_wr_o,
  output logic              presc_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned IDX_W = ADDR_W - IDX_LSB;

  logic [IDX_W-1:0] idx;
  logic [REG_N-1:0] wr_sel;
  logic             unused_addr;

  assign idx         = addr_i[ADDR_W-1:IDX_LSB];
  assign unused_addr = ^addr_i[IDX_LSB-1:0];

  for (genvar g = 0; g < REG_N; g++) begin : g_dec
    assign wr_sel[g] = we_i && (idx == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_o  <= '0;
      en_o   <= 1'b0;
      ctrl_o <= '0;
    end else begin
      if (wr_sel[REG_CMP])  cmp_o  <= wdata_i;
      if (wr_sel[REG_EN])   en_o   <= wdata_i[0];
      if (wr_sel[REG_CTRL]) ctrl_o <= wdata_i[CTRL_W-1:0];
    end
  end

  assign cnt_wr_o    = wr_sel[REG_CNT];
  assign en_wr_o     = wr_sel[REG_EN];
  // R5 / R6: prescaler restart
  assign presc_clr_o = wr_sel[REG_CNT] || (wr_sel[REG_EN] && !wdata_i[0]);

  always_comb begin
    rdata_o = '0;
    unique case (idx)
      IDX_W'(REG_CMP):  rdata_o = cmp_o;
      IDX_W'(REG_EN):   rdata_o = DATA_W'(en_o);
      IDX_W'(REG_CNT):  rdata_o = cnt_i;
      IDX_W'(REG_CTRL): rdata_o = DATA_W'(ctrl_o);
      default:          rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int unsigned MAX_CODE = 5,
  parameter int unsigned PRE_W    = 2 * MAX_CODE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              step_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;
  int unsigned      eff;

  // codes above MAX_CODE saturate to the largest divider (R4)
  always_comb begin
    eff   = (32'(code_i) > MAX_CODE) ? MAX_CODE : 32'(code_i);
    limit = PRE_W'((32'd1 << (2 * eff)) - 32'd1);
  end

  assign step_o = tick_i && (pre_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (tick_i) pre_q <= step_o ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cnt_wr_i,
  input  logic              en_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cmp_i,
  input  logic              step_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              run_o,
  output logic              reset_req_o
);
  localparam int unsigned PULSE_W = $clog2(PULSE_LEN + 1);

  logic               halted_q;
  logic               hit;
  logic [PULSE_W-1:0] pulse_q;

  assign hit   = en_i && !halted_q && (cnt_o == cmp_i);
  assign run_o = en_i && !halted_q && !hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (cnt_wr_i)          cnt_o <= wdata_i;  // R6, R8: write wins
    else if (run_o && step_i)   cnt_o <= cnt_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       halted_q <= 1'b0;
    else if (cnt_wr_i) halted_q <= 1'b0;
    else if (hit)      halted_q <= 1'b1;
    else if (en_wr_i)  halted_q <= 1'b0;  // R9
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                pulse_q <= '0;
    else if (hit && !cnt_wr_i && pulse_q == '0) pulse_q <= PULSE_W'(PULSE_LEN);
    else if (pulse_q != '0)                     pulse_q <= pulse_q - 1'b1;
  end

  assign reset_req_o = (pulse_q != '0);
endmodule

// File: rtl/presc_watchdog.sv
module presc_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned MAX_CODE  = 5,
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [SRC_N-1:0]  tick_i,
  output logic              reset_req_o
);
  logic [DATA_W-1:0] cmp_val;
  logic [DATA_W-1:0] cnt_val;
  logic              en_val;
  wdt_ctrl_t         ctrl_val;
  logic              cnt_wr;
  logic              en_wr;
  logic              presc_clr;
  logic              run;
  logic              step;
  logic [SRC_N-1:0]  src_tick;

  wdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .we_i       (we_i),
    .cnt_i      (cnt_val),
    .cmp_o      (cmp_val),
    .en_o       (en_val),
    .ctrl_o     (ctrl_val),
    .cnt_wr_o   (cnt_wr),
    .en_wr_o    (en_wr),
    .presc_clr_o(presc_clr),
    .rdata_o    (rdata_o)
  );

  // R3: one-hot style source gating
  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    assign src_tick[g] = tick_i[g] && ctrl_val.src[g];
  end

  wdt_prescaler #(.MAX_CODE(MAX_CODE)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (presc_clr),
    .tick_i((|src_tick) && run),
    .code_i(ctrl_val.code),
    .step_o(step)
  );

  wdt_core #(.DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_val),
    .cnt_wr_i   (cnt_wr),
    .en_wr_i    (en_wr),
    .wdata_i    (wdata_i),
    .cmp_i      (cmp_val),
    .step_i     (step),
    .cnt_o      (cnt_val),
    .run_o      (run),
    .reset_req_o(reset_req_o)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned PULSE_LEN = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic              reset_req_o,
  input logic [DATA_W-1:0] cnt_i,
  input logic [DATA_W-1:0] cmp_i,
  input logic              en_i
);
  localparam int unsigned RUN_W = $clog2(PULSE_LEN + 2) + 1;

  logic             cnt_write;
  logic [RUN_W-1:0] run_q;

  assign cnt_write = we_i && (addr_i[ADDR_W-1:2] == (ADDR_W-2)'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= '0;
    else if (reset_req_o) run_q <= run_q + 1'b1;
    else                  run_q <= '0;
  end

  a_r6_cnt_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_write |=> cnt_i == $past(wdata_i));

  a_r5_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_write) |=> $stable(cnt_i));

  a_r4_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_write |=> (cnt_i == $past(cnt_i)) || (cnt_i == DATA_W'($past(cnt_i) + 1'b1)));

  a_r7_rise_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_req_o) |-> $past(en_i && (cnt_i == cmp_i)));

  a_r7_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reset_req_o) |-> run_q == RUN_W'(PULSE_LEN));

  a_r7_pulse_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_W'(PULSE_LEN));

  a_r8_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_write && !reset_req_o) |=> !reset_req_o);
endmodule

bind presc_watchdog wdt_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .we_i       (we_i),
  .reset_req_o(reset_req_o),
  .cnt_i      (cnt_val),
  .cmp_i      (cmp_val),
  .en_i       (en_val)
);

// File: tb/tb_presc_watchdog.sv
`timescale 1ns/1ps
module tb_presc_watchdog;
  localparam logic [3:0] A_CMP = 4'h0, A_EN = 4'h4, A_CNT = 4'h8, A_CTRL = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic [15:0] rdata;
  logic [2:0]  tick = '0;
  logic        req;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  presc_watchdog dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .tick_i(tick), .reset_req_o(req)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input logic [2:0] m, input int n);
    tick = m;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick = '0;
  endtask

  task automatic chk_cnt(input string tag, input logic [15:0] exp);
    logic [15:0] v;
    rd(A_CNT, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(A_CMP, v);  check("R1 cmp", v, 16'h0);
    rd(A_EN, v);   check("R1 en", v, 16'h0);
    rd(A_CNT, v);  check("R1 cnt", v, 16'h0);
    rd(A_CTRL, v); check("R1 ctrl", v, 16'h0);
    check("R1 req", 16'(req), 16'h0);
  endtask

  task automatic t_readback();
    logic [15:0] v;
    wr(A_CMP, 16'h1234);  rd(A_CMP, v);  check("R2 cmp", v, 16'h1234);
    wr(A_CTRL, 16'hFFFF); rd(A_CTRL, v); check("R2 ctrl mask", v, 16'h003F);
    wr(A_EN, 16'hFFFF);   rd(A_EN, v);   check("R2 en mask", v, 16'h0001);
    wr(A_EN, 16'h0);
    wr(A_CNT, 16'hABCD);  rd(4'hB, v);   check("R2 low addr bits", v, 16'hABCD);
  endtask

  task automatic t_source();
    wr(A_CTRL, 16'h0001); wr(A_CMP, 16'h0100); wr(A_CNT, 16'h0); wr(A_EN, 16'h1);
    ticks(3'b001, 5);  chk_cnt("R3 src0", 16'd5);
    ticks(3'b110, 4);  chk_cnt("R3 unselected", 16'd5);
    wr(A_CTRL, 16'h0002); ticks(3'b010, 3); chk_cnt("R3 src1", 16'd8);
    wr(A_CTRL, 16'h0004); ticks(3'b100, 2); chk_cnt("R3 src2", 16'd10);
    wr(A_CTRL, 16'h0000); ticks(3'b111, 3); chk_cnt("R3 none", 16'd10);
  endtask

  task automatic t_prescale();
    wr(A_CMP, 16'hF000);
    for (int c = 1; c < 8; c++) begin
      int d = (c > 5) ? 1024 : (1 << (2 * c));
      wr(A_CTRL, 16'((c << 3) | 1)); wr(A_CNT, 16'h0);
      ticks(3'b001, d - 1); chk_cnt($sformatf("R4 code%0d below", c), 16'd0);
      ticks(3'b001, 1);     chk_cnt($sformatf("R4 code%0d step", c), 16'd1);
    end
    wr(A_CTRL, 16'h0009); wr(A_CNT, 16'h0); ticks(3'b001, 12);
    chk_cnt("R4 div4 x3", 16'd3);
    wr(A_CMP, 16'h0100); wr(A_CTRL, 16'h0001); wr(A_CNT, 16'hFFFF); ticks(3'b001, 1);
    chk_cnt("R4 wrap", 16'd0);
  endtask

  task automatic t_enable();
    wr(A_CTRL, 16'h0009); wr(A_CNT, 16'h0);
    ticks(3'b001, 3); wr(A_EN, 16'h0);
    ticks(3'b001, 10); chk_cnt("R5 disabled hold", 16'd0);
    wr(A_EN, 16'h1);
    ticks(3'b001, 3); chk_cnt("R5 prescaler cleared", 16'd0);
    ticks(3'b001, 1); chk_cnt("R5 resumed", 16'd1);
  endtask

  task automatic t_kick();
    ticks(3'b001, 5); chk_cnt("R6 before kick", 16'd2);
    wr(A_CNT, 16'h0);
    ticks(3'b001, 3); chk_cnt("R6 full period", 16'd0);
    ticks(3'b001, 1); chk_cnt("R6 step", 16'd1);
    wr(A_CNT, 16'h0042); chk_cnt("R6 load", 16'h0042);
  endtask

  task automatic t_timeout();
    int hi = 0;
    logic first;
    wr(A_CTRL, 16'h0001); wr(A_CMP, 16'd5); wr(A_CNT, 16'h0);
    ticks(3'b001, 5);
    check("R7 no early req", 16'(req), 16'h0);
    chk_cnt("R7 at match", 16'd5);
    tick = 3'b001;
    @(negedge clk); first = req;
    if (req) hi++;
    for (int i = 0; i < 19; i++) begin
      @(negedge clk);
      if (req) hi++;
    end
    tick = '0;
    check("R7 req next cycle", 16'(first), 16'h1);
    check("R7 req width", 16'(hi), 16'd16);
    chk_cnt("R7 frozen", 16'd5);
    wr(A_CNT, 16'h0); ticks(3'b001, 2); chk_cnt("R7 rearm", 16'd2);
  endtask

  task automatic t_collision();
    int hi = 0;
    wr(A_CNT, 16'd4); ticks(3'b001, 1);
    chk_cnt("R8 at match", 16'd5);
    wr(A_CNT, 16'h0);  // same cycle as visible match
    for (int i = 0; i < 20; i++) begin
      if (req) hi++;
      @(negedge clk);
    end
    check("R8 no req", 16'(hi), 16'd0);
    chk_cnt("R8 loaded", 16'd0);
  endtask

  task automatic t_reenable();
    logic [15:0] v;
    wr(A_CMP, 16'd3); wr(A_CNT, 16'h0); ticks(3'b001, 3);
    repeat (20) @(negedge clk);
    ticks(3'b001, 2); chk_cnt("R9 halted", 16'd3);
    wr(A_CMP, 16'd10); wr(A_EN, 16'h0); wr(A_EN, 16'h1);
    ticks(3'b001, 2); chk_cnt("R9 resumed", 16'd5);
    rd(A_CMP, v); check("R9 new cmp", v, 16'd10);
    check("R9 no req", 16'(req), 16'h0);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_source();
    t_prescale();
    t_enable();
    t_kick();
    t_timeout();
    t_collision();
    t_reenable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule